// File: doc/BRIEF.md
# Vector Register Bank with Word-Offset Sequencer

This block is one bank of a split vector register file. It stores sixteen vector registers of `VLEN` bits. Each register is held as `VLEN/ELEN` words of `ELEN` bits. A two-bank vector unit uses two copies of it. The copy with `BANK_ID = 0` owns architectural registers 0 to 15, and the copy with `BANK_ID = 1` owns 16 to 31. Because each lane has its own copy, both lanes can run at the same time without arbitration.

An operation begins with a `start` pulse. The pulse is accepted only when the destination register number belongs to this bank. It captures the element width, the vector length and the three register numbers. A built-in sequencer then walks the word offsets of the registers, one word each cycle that `step` is high.

At every position the bank does three things:
- It presents the current word of two source registers on its read ports.
- It accepts one write-back word for the destination register.
- It produces a per-byte write-enable mask, so that only the bytes of elements below the vector length are changed.

Top module: `vreg_bank`

## Requirements
- R1: After reset, `busy`, `done` and `wr_mask` are 0, and every stored byte reads back as 0.
- R2: A `start` whose `rd` upper bit equals `BANK_ID` makes `busy` 1, `done` 0 and `byte_off` 0 on the next cycle. This also holds when an operation is already in progress, which is then abandoned.
- R3: A `start` whose `rd` belongs to the other bank is ignored, and `busy` stays as it was.
- R4: While busy, `byte_off` grows by 8 on each clock where `step` is 1, and holds its value when `step` is 0.
- R5: A `step` at the last word (`byte_off` = 24) clears `busy` and sets `done` on the next cycle. `done` stays 1 until the next accepted `start`.
- R6: While busy, bit b of `wr_mask` is 1 exactly when element number `(8*w + b) >> sew` is below `vl`, where w = `byte_off`/8. The `sew` codes are 0, 1, 2 and 3 for 8, 16, 32 and 64-bit elements, and byte b is bits `8b+7:8b` of a word.
- R7: The mask always covers whole elements. For a 16-bit width it sets bytes in pairs, for 32 bits in groups of four, and for 64 bits all eight bytes together.
- R8: A clock with `busy` and `wr_en` high writes the bytes of `wr_data` selected by `wr_mask` into word w of register `rd` mod 16. All other bytes keep their old value.
- R9: `rd_a_data` and `rd_b_data` show word w of registers `rs_a` and `rs_b` (mod 16). A read of the word being written in the same cycle returns the old data, and the new data appears from the following cycle.
- R10: `wr_en` while idle changes no stored data.
- R11: While idle, `wr_mask` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an operation with the controls below |
| step | input | 1 | Advance to the next word |
| sew | input | 2 | Element width code, captured at start |
| vl | input | 6 | Active element count, captured at start |
| rs_a | input | 5 | Source register A (architectural number) |
| rs_b | input | 5 | Source register B (architectural number) |
| rd | input | 5 | Destination register; its upper bit picks the bank |
| wr_en | input | 1 | Write-back strobe for the current word |
| wr_data | input | 64 | Write-back word |
| rd_a_data | output | 64 | Current word of source A |
| rd_b_data | output | 64 | Current word of source B |
| byte_off | output | 5 | Byte offset of the current word inside a register |
| wr_mask | output | 8 | Byte write-enable for the current word |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Last word has been passed |

## Verification
The assertions assume that `start` is only pulsed with a `rd` that can be decoded, and that `sew` and `vl` are meaningful only at the accepted `start`, so the checker reads the captured width rather than the live input. They also assume that the source registers named at `start` lie in the same bank, since only the low four bits are used. The stimulus always pulses `start` for one cycle, keeps the source numbers inside bank 0, and changes inputs only between clock edges. Foreign-bank starts are issued only to test that they are ignored.

// File: rtl/vrb_pkg.sv
// Shared definitions for the vector register bank.
// Assumes byte-granular elements with a power-of-two width in bytes.
package vrb_pkg;
    // Element width code carried on the sew port.
    typedef enum logic [1:0] {
        EW8  = 2'd0,
        EW16 = 2'd1,
        EW32 = 2'd2,
        EW64 = 2'd3
    } ew_t;
endpackage

// File: rtl/vrb_offset_gen.sv
// Word-offset sequencer: walks word indices 0..WPR-1 while stepped.
// Assumes start_ok is already qualified by bank ownership.
module vrb_offset_gen #(
    parameter int WPR    = 4,
    localparam int WIDX_W = (WPR > 1) ? $clog2(WPR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ok,
    input  logic              step,
    output logic [WIDX_W-1:0] word_idx,
    output logic              busy,
    output logic              done
);
    localparam logic [WIDX_W-1:0] LAST = WIDX_W'(WPR - 1);

    // Sequencer state: restart on start, advance on step, finish at LAST.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_idx <= '0;
            busy     <= 1'b0;
            done     <= 1'b0;
        end else if (start_ok) begin
            word_idx <= '0;
            busy     <= 1'b1;
            done     <= 1'b0;
        end else if (busy && step) begin
            if (word_idx == LAST) begin
                busy <= 1'b0;
                done <= 1'b1;
            end else begin
                word_idx <= word_idx + 1'b1;
            end
        end
    end
endmodule

// File: rtl/vrb_mask_gen.sv
// Byte write-enable builder: a byte is enabled when the element containing it
// has an index below vl. Assumes sew codes 0..3 mean 1,2,4,8 bytes per element.
module vrb_mask_gen #(
    parameter int VLEN = 256,
    parameter int ELEN = 64,
    localparam int BPW    = ELEN / 8,
    localparam int WPR    = VLEN / ELEN,
    localparam int WIDX_W = (WPR > 1) ? $clog2(WPR) : 1,
    localparam int BSEL_W = $clog2(BPW),
    localparam int OFF_W  = $clog2(VLEN / 8),
    localparam int VL_W   = OFF_W + 1
) (
    input  logic              busy,
    input  logic [1:0]        sew,
    input  logic [VL_W-1:0]   vl,
    input  logic [WIDX_W-1:0] word_idx,
    output logic [BPW-1:0]    mask
);
    for (genvar b = 0; b < BPW; b++) begin : g_byte
        logic [OFF_W-1:0] gbyte;
        logic [OFF_W-1:0] elem;
        // Element index of this byte lane and its tail comparison.
        always_comb begin
            gbyte   = (OFF_W'(word_idx) << BSEL_W) | OFF_W'(b);
            elem    = gbyte >> sew;
            mask[b] = busy && (VL_W'(elem) < vl);
        end
    end
endmodule

// File: rtl/vrb_storage.sv
// Register storage of one bank: NREGS registers of WPR words, two
// combinational read ports, one byte-masked write port. A read of the word
// under write sees the pre-edge value. Assumes indices are in range.
module vrb_storage #(
    parameter int NREGS = 16,
    parameter int WPR   = 4,
    parameter int ELEN  = 64,
    localparam int BPW    = ELEN / 8,
    localparam int REG_W  = $clog2(NREGS),
    localparam int WIDX_W = (WPR > 1) ? $clog2(WPR) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [REG_W-1:0]  ra,
    input  logic [REG_W-1:0]  rb,
    input  logic [WIDX_W-1:0] widx,
    output logic [ELEN-1:0]   qa,
    output logic [ELEN-1:0]   qb,
    input  logic              we,
    input  logic [REG_W-1:0]  wr,
    input  logic [BPW-1:0]    wmask,
    input  logic [ELEN-1:0]   wd
);
    logic [ELEN-1:0] mem [NREGS][WPR];

    // Clear on reset, otherwise merge enabled bytes into the addressed word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int r = 0; r < NREGS; r++)
                for (int w = 0; w < WPR; w++)
                    mem[r][w] <= '0;
        end else if (we) begin
            for (int b = 0; b < BPW; b++)
                if (wmask[b])
                    mem[wr][widx][b*8 +: 8] <= wd[b*8 +: 8];
        end
    end

    // Read ports.
    always_comb begin
        qa = mem[ra][widx];
        qb = mem[rb][widx];
    end
endmodule

// File: rtl/vreg_bank.sv
// One bank of a split vector register file with its own offset sequencer.
// Accepts an operation only when the destination belongs to BANK_ID; the
// source numbers are assumed to lie in the same bank (low bits used).
module vreg_bank #(
    parameter int NREGS   = 16,
    parameter int NBANKS  = 2,
    parameter int BANK_ID = 0,
    parameter int VLEN    = 256,
    parameter int ELEN    = 64,
    localparam int BPW    = ELEN / 8,
    localparam int WPR    = VLEN / ELEN,
    localparam int WIDX_W = (WPR > 1) ? $clog2(WPR) : 1,
    localparam int REG_W  = $clog2(NREGS),
    localparam int AREG_W = REG_W + $clog2(NBANKS),
    localparam int OFF_W  = $clog2(VLEN / 8),
    localparam int VL_W   = OFF_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              step,
    input  logic [1:0]        sew,
    input  logic [VL_W-1:0]   vl,
    input  logic [AREG_W-1:0] rs_a,
    input  logic [AREG_W-1:0] rs_b,
    input  logic [AREG_W-1:0] rd,
    input  logic              wr_en,
    input  logic [ELEN-1:0]   wr_data,
    output logic [ELEN-1:0]   rd_a_data,
    output logic [ELEN-1:0]   rd_b_data,
    output logic [OFF_W-1:0]  byte_off,
    output logic [BPW-1:0]    wr_mask,
    output logic              busy,
    output logic              done
);
    import vrb_pkg::*;

    localparam int BSEL_W = $clog2(BPW);

    logic              start_ok;
    logic [WIDX_W-1:0] word_idx;
    ew_t               sew_q;
    logic [VL_W-1:0]   vl_q;
    logic [REG_W-1:0]  ra_q, rb_q, rd_q;

    // Bank ownership of the destination register.
    always_comb start_ok = start && (32'(rd >> REG_W) == BANK_ID);

    // Capture per-operation controls, held for the whole operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sew_q <= EW8;
            vl_q  <= '0;
            ra_q  <= '0;
            rb_q  <= '0;
            rd_q  <= '0;
        end else if (start_ok) begin
            sew_q <= ew_t'(sew);
            vl_q  <= vl;
            ra_q  <= rs_a[REG_W-1:0];
            rb_q  <= rs_b[REG_W-1:0];
            rd_q  <= rd[REG_W-1:0];
        end
    end

    vrb_offset_gen #(.WPR(WPR)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_ok (start_ok),
        .step     (step),
        .word_idx (word_idx),
        .busy     (busy),
        .done     (done)
    );

    vrb_mask_gen #(.VLEN(VLEN), .ELEN(ELEN)) u_mask (
        .busy     (busy),
        .sew      (sew_q),
        .vl       (vl_q),
        .word_idx (word_idx),
        .mask     (wr_mask)
    );

    vrb_storage #(.NREGS(NREGS), .WPR(WPR), .ELEN(ELEN)) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .ra    (ra_q),
        .rb    (rb_q),
        .widx  (word_idx),
        .qa    (rd_a_data),
        .qb    (rd_b_data),
        .we    (busy && wr_en),
        .wr    (rd_q),
        .wmask (wr_mask),
        .wd    (wr_data)
    );

    // Byte offset of the current word.
    always_comb byte_off = OFF_W'(word_idx) << BSEL_W;
endmodule

// File: rtl/vreg_bank_chk.sv
// Property checker for vreg_bank, attached by bind below.
module vreg_bank_chk #(
    parameter int BANK_ID = 0,
    parameter int REG_W   = 4,
    parameter int AREG_W  = 5,
    parameter int OFF_W   = 5,
    parameter int BPW     = 8,
    parameter int LAST_OFF = 24
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic              step,
    input logic [AREG_W-1:0] rd,
    input logic [OFF_W-1:0]  byte_off,
    input logic [BPW-1:0]    wr_mask,
    input logic              busy,
    input logic              done,
    input logic [1:0]        sew_q
);
    logic own;
    always_comb own = start && (32'(rd >> REG_W) == BANK_ID);

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        own |=> busy && !done && byte_off == '0);
    // R3
    foreign_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start && !own && !busy |=> !busy);
    // R4
    offset_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && step && !own && byte_off != OFF_W'(LAST_OFF)
        |=> byte_off == $past(byte_off) + OFF_W'(8));
    // R4
    offset_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !step && !own |=> $stable(byte_off) && busy);
    // R5
    finish_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && step && !own && byte_off == OFF_W'(LAST_OFF) |=> done && !busy);
    // R5
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done && !own |=> done);
    // R11
    idle_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> wr_mask == '0);
    // R6
    tail_prefix_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (wr_mask & (wr_mask + 1'b1)) == '0);
    // R7
    whole_elem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy && sew_q != 2'd0 |->
            (sew_q == 2'd1 && ((wr_mask ^ (wr_mask >> 1)) & 8'h55) == '0) ||
            (sew_q == 2'd2 && (wr_mask == 8'h00 || wr_mask == 8'h0F || wr_mask == 8'hFF)) ||
            (sew_q == 2'd3 && (wr_mask == 8'h00 || wr_mask == 8'hFF)));
endmodule

bind vreg_bank vreg_bank_chk #(
    .BANK_ID  (BANK_ID),
    .REG_W    (REG_W),
    .AREG_W   (AREG_W),
    .OFF_W    (OFF_W),
    .BPW      (BPW),
    .LAST_OFF ((WPR - 1) * BPW)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .step     (step),
    .rd       (rd),
    .byte_off (byte_off),
    .wr_mask  (wr_mask),
    .busy     (busy),
    .done     (done),
    .sew_q    (sew_q)
);

// File: tb/sim_vreg_bank.sv
module sim_vreg_bank;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, step = 1'b0, wr_en = 1'b0;
    logic [1:0]  sew = '0;
    logic [5:0]  vl = '0;
    logic [4:0]  rs_a = '0, rs_b = '0, rd = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_a_data, rd_b_data;
    logic [4:0]  byte_off;
    logic [7:0]  wr_mask;
    logic        busy, done;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    vreg_bank u0 (.*);

    // {sew, vl, word, expected mask}
    localparam int NV = 12;
    localparam logic [17:0] TBL [NV] = '{
        {2'd0, 6'd5,  2'd0, 8'h1F},
        {2'd0, 6'd5,  2'd1, 8'h00},
        {2'd0, 6'd13, 2'd1, 8'h1F},
        {2'd0, 6'd32, 2'd3, 8'hFF},
        {2'd1, 6'd3,  2'd0, 8'h3F},
        {2'd1, 6'd6,  2'd1, 8'h0F},
        {2'd2, 6'd3,  2'd0, 8'hFF},
        {2'd2, 6'd3,  2'd1, 8'h0F},
        {2'd2, 6'd7,  2'd3, 8'h0F},
        {2'd3, 6'd2,  2'd1, 8'hFF},
        {2'd3, 6'd2,  2'd2, 8'h00},
        {2'd3, 6'd0,  2'd0, 8'h00}
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic go(logic [1:0] s, logic [5:0] v, logic [4:0] d, logic [4:0] a, logic [4:0] b);
        start = 1'b1; sew = s; vl = v; rd = d; rs_a = a; rs_b = b;
        tick();
        start = 1'b0;
    endtask

    task automatic steps(int n);
        step = 1'b1;
        repeat (n) tick();
        step = 1'b0;
    endtask

    function automatic logic [63:0] pat(int w);
        return 64'h1122334455667788 + 64'h0101010101010101 * 64'(w);
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 busy", 64'(busy), 0);
        chk("R1 done", 64'(done), 0);
        chk("R1 mask", 64'(wr_mask), 0);

        // R6 mask table
        for (int i = 0; i < NV; i++) begin
            logic [1:0] s; logic [5:0] v; logic [1:0] w; logic [7:0] m;
            {s, v, w, m} = TBL[i];
            go(s, v, 5'd0, 5'd0, 5'd0);
            if (w != 0) steps(int'(w));
            chk("R6 mask", 64'(wr_mask), 64'(m));
            steps(4 - int'(w));
        end

        // R1 storage cleared: read register 5
        go(2'd3, 6'd4, 5'd0, 5'd5, 5'd5);
        chk("R1 rdata", rd_a_data, 64'd0);
        chk("R2 off", 64'(byte_off), 0);
        chk("R2 busy", 64'(busy), 1);
        steps(4);

        // R8 fill register 3 fully
        go(2'd3, 6'd4, 5'd3, 5'd3, 5'd3);
        for (int w = 0; w < 4; w++) begin
            wr_data = pat(w); wr_en = 1'b1; step = 1'b1;
            tick();
        end
        wr_en = 1'b0; step = 1'b0;
        // R5 done after last step
        chk("R5 done", 64'(done), 1);
        chk("R5 busy", 64'(busy), 0);
        tick(); tick();
        chk("R5 done hold", 64'(done), 1);

        // R4, R9 read back with offsets
        go(2'd0, 6'd0, 5'd0, 5'd3, 5'd3);
        chk("R2 done clr", 64'(done), 0);
        for (int w = 0; w < 4; w++) begin
            chk("R4 off", 64'(byte_off), 64'(8 * w));
            chk("R9 portA", rd_a_data, pat(w));
            chk("R9 portB", rd_b_data, pat(w));
            tick();
            chk("R4 hold", 64'(byte_off), 64'(8 * w));
            steps(1);
        end

        // R8 partial write: sew8 vl=3 zero bytes 0..2 of word 0 only
        go(2'd0, 6'd3, 5'd3, 5'd3, 5'd3);
        wr_data = 64'd0; wr_en = 1'b1;
        steps(4);
        wr_en = 1'b0;
        go(2'd0, 6'd0, 5'd0, 5'd3, 5'd3);
        chk("R8 word0", rd_a_data, pat(0) & 64'hFFFF_FFFF_FF00_0000);
        steps(1);
        chk("R8 word1", rd_a_data, pat(1));
        steps(3);

        // R9 same-cycle write returns old data, new data next cycle
        go(2'd3, 6'd4, 5'd3, 5'd3, 5'd4);
        steps(2);
        wr_data = 64'hDEAD_BEEF_CAFE_F00D; wr_en = 1'b1;
        chk("R9 old", rd_a_data, pat(2));
        tick();
        wr_en = 1'b0;
        chk("R9 new", rd_a_data, 64'hDEAD_BEEF_CAFE_F00D);
        chk("R8 other reg", rd_b_data, 64'd0);

        // R12-style restart: R2 start while busy resets offset
        go(2'd3, 6'd4, 5'd3, 5'd3, 5'd3);
        chk("R2 restart off", 64'(byte_off), 0);
        steps(4);

        // R10 idle write ignored
        wr_data = 64'hFFFF_FFFF_FFFF_FFFF; wr_en = 1'b1;
        tick(); tick();
        wr_en = 1'b0;
        chk("R11 idle mask", 64'(wr_mask), 0);
        go(2'd0, 6'd0, 5'd0, 5'd3, 5'd3);
        chk("R10 unchanged", rd_a_data, pat(0) & 64'hFFFF_FFFF_FF00_0000);
        steps(4);

        // R3 foreign destination ignored
        go(2'd3, 6'd4, 5'd17, 5'd3, 5'd3);
        chk("R3 busy", 64'(busy), 0);
        chk("R3 done kept", 64'(done), 1);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule